// File: doc/BRIEF.md
# Crystal Oscillator Failure Detector

This block watches a crystal clock and requests a system reset when the crystal slows or stops. A reference time base, delivered as a one-cycle tick strobe in the block's own clock domain, is counted between rising edges of the crystal. The crystal signal arrives already sampled into that domain. When more ticks go by than one period of the failure frequency allows, the crystal is declared failed. The failure frequency is about 30 kHz by default.

A failure raises a one-cycle reset request and sets a sticky cause flag, but only while detection is enabled. The crystal may also be stopped deliberately, either by the low-power stop mode or while the processor runs from its internal ring oscillator. In both cases the count is held at zero, so neither a reset nor the flag can result. The flag is cleared only by power-on reset or by a software clear strobe. It therefore survives the system reset it has just requested, and software can read the cause afterwards.

Top module: `osc_fail_detector`

## Requirements
- R1: After power-on reset (rstN low), sysResetReq and failFlag are both 0.
- R2: The detector counts clock cycles in which refTick is 1. A rising edge of xtalLevel (1 in a cycle after a cycle at 0) restarts the count at zero. Cycles with refTick at 0 add nothing. When the count reaches TICK_LIMIT+1, with TICK_LIMIT = REF_FREQ_HZ / FAIL_FREQ_HZ, sysResetReq goes high on the following clock edge.
- R3: sysResetReq is high for exactly one cycle, and the count restarts from zero in that same cycle. If no crystal edge arrives, the next request comes TICK_LIMIT+2 ticked cycles later.
- R4: While detectEn is 0, no reset request is produced, and failFlag keeps its value whether it was 0 or 1.
- R5: While stopMode is 1, the count is held at zero, so no reset request and no flag change result. After stopMode returns to 0, a request needs a full TICK_LIMIT+2 ticked cycles.
- R6: While ringOscActive is 1, the same suppression and restart as in R5 apply.
- R7: failFlag becomes 1 in the same cycle that sysResetReq is 1. It stays 1 without further failures until it is cleared.
- R8: A flagClr pulse clears failFlag on the next clock edge. If a failure falls on that same edge, the flag stays set.
- R9: While detectEn is 0 the count saturates at TICK_LIMIT+1. Raising detectEn in that state gives a reset request on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, the domain of all inputs |
| rstN | input | 1 | Power-on reset, active low, asynchronous |
| refTick | input | 1 | One-cycle strobe of the reference time base |
| xtalLevel | input | 1 | Crystal clock, already sampled into this domain |
| detectEn | input | 1 | Enables reset requests on failure |
| stopMode | input | 1 | Crystal halted on purpose by stop mode |
| ringOscActive | input | 1 | Processor running from the internal ring oscillator |
| flagClr | input | 1 | Software strobe that clears the fail flag |
| sysResetReq | output | 1 | One-cycle system reset request |
| failFlag | output | 1 | Sticky flag recording a failure-caused reset |

## Verification
The in-line properties check every cycle that the count never passes its saturation value and that a request never lasts two cycles. They also check that no request follows a cycle with detection disabled or with the crystal deliberately stopped, and that the flag rises only with a request and falls only after a clear. The exact request spacing for every gap length can be shown only by the bench's scenarios, which sweep the gap between crystal edges across several multiples of the limit. The same holds for the restart of the count after suppression ends, the immediate request when detection is enabled late, and the precedence of a set over a clear.

// File: rtl/osc_fail_pkg.sv
package osc_fail_pkg;

  // Strobes driven by the control toward the tick counter datapath.
  typedef struct packed {
    logic clearCnt;   // restart the tick count at zero
    logic countTick;  // one reference tick elapsed this cycle
  } oscStrobe_t;

endpackage

// File: rtl/osc_fail_datapath.sv
module osc_fail_datapath
  import osc_fail_pkg::*;
#(
  parameter int unsigned LIMIT = 33,
  localparam int unsigned CNT_W = $clog2(LIMIT + 2)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       xtalLevel,
  input  oscStrobe_t strb,
  output logic       xtalRise,
  output logic       overLimit
);

  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(LIMIT + 1);

  logic             xtalQ;
  logic [CNT_W-1:0] tickCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) xtalQ <= 1'b0;
    else       xtalQ <= xtalLevel;
  end

  assign xtalRise  = xtalLevel & ~xtalQ;
  assign overLimit = (tickCnt == CNT_TOP);

  // Saturating counter of reference ticks since the last crystal edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           tickCnt <= '0;
    else if (strb.clearCnt)              tickCnt <= '0;
    else if (strb.countTick && !overLimit) tickCnt <= tickCnt + 1'b1;
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    tickCnt <= CNT_TOP);

  // R2
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.clearCnt && !strb.countTick) |=> $stable(tickCnt));

  // R3
  cnt_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearCnt |=> !overLimit);

endmodule

// File: rtl/osc_fail_control.sv
module osc_fail_control
  import osc_fail_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       refTick,
  input  logic       detectEn,
  input  logic       stopMode,
  input  logic       ringOscActive,
  input  logic       flagClr,
  input  logic       xtalRise,
  input  logic       overLimit,
  output oscStrobe_t strb,
  output logic       sysResetReq,
  output logic       failFlag
);

  logic suppress;
  logic fire;

  // A deliberately stopped crystal is never treated as a failure.
  assign suppress = stopMode | ringOscActive;
  assign fire     = overLimit & detectEn & ~suppress;

  always_comb begin
    strb           = '0;
    strb.clearCnt  = xtalRise | suppress | fire;
    strb.countTick = refTick;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sysResetReq <= 1'b0;
    else       sysResetReq <= fire;
  end

  // Sticky cause flag: a new failure wins over a software clear.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        failFlag <= 1'b0;
    else if (fire)    failFlag <= 1'b1;
    else if (flagClr) failFlag <= 1'b0;
  end

  // R3
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    sysResetReq |=> !sysResetReq);

  // R4
  en_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !detectEn |=> !sysResetReq);

  // R5
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopMode |=> !sysResetReq);

  // R6
  ring_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ringOscActive |=> !sysResetReq);

  // R7
  flag_with_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    sysResetReq |-> failFlag);

  // R7
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(failFlag) |-> sysResetReq);

  // R8
  flag_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(failFlag) |-> $past(flagClr));

endmodule

// File: rtl/osc_fail_detector.sv
module osc_fail_detector
  import osc_fail_pkg::*;
#(
  parameter int unsigned REF_FREQ_HZ  = 1_000_000,
  parameter int unsigned FAIL_FREQ_HZ = 30_000
) (
  input  logic clk,
  input  logic rstN,
  input  logic refTick,
  input  logic xtalLevel,
  input  logic detectEn,
  input  logic stopMode,
  input  logic ringOscActive,
  input  logic flagClr,
  output logic sysResetReq,
  output logic failFlag
);

  localparam int unsigned TICK_LIMIT = REF_FREQ_HZ / FAIL_FREQ_HZ;

  oscStrobe_t strb;
  logic       xtalRise;
  logic       overLimit;

  osc_fail_datapath #(.LIMIT(TICK_LIMIT)) uDatapath (
    .clk       (clk),
    .rstN      (rstN),
    .xtalLevel (xtalLevel),
    .strb      (strb),
    .xtalRise  (xtalRise),
    .overLimit (overLimit)
  );

  osc_fail_control uControl (
    .clk           (clk),
    .rstN          (rstN),
    .refTick       (refTick),
    .detectEn      (detectEn),
    .stopMode      (stopMode),
    .ringOscActive (ringOscActive),
    .flagClr       (flagClr),
    .xtalRise      (xtalRise),
    .overLimit     (overLimit),
    .strb          (strb),
    .sysResetReq   (sysResetReq),
    .failFlag      (failFlag)
  );

endmodule

// File: tb/osc_fail_detector_test.sv
`timescale 1ns/1ps
module osc_fail_detector_test;

  localparam int REF_HZ  = 120_000;
  localparam int FAIL_HZ = 30_000;
  localparam int LIM     = REF_HZ / FAIL_HZ;   // 4
  localparam int PER     = LIM + 2;            // ticked cycles between requests

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refTick = 1'b1;
  logic xtalLevel = 1'b0;
  logic detectEn = 1'b1;
  logic stopMode = 1'b0;
  logic ringOscActive = 1'b0;
  logic flagClr = 1'b0;
  logic sysResetReq, failFlag;

  int total = 0;
  int bad = 0;
  int dbl = 0;
  bit prevHigh = 1'b0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  osc_fail_detector #(.REF_FREQ_HZ(REF_HZ), .FAIL_FREQ_HZ(FAIL_HZ)) uut (
    .clk(clk), .rstN(rstN), .refTick(refTick), .xtalLevel(xtalLevel),
    .detectEn(detectEn), .stopMode(stopMode), .ringOscActive(ringOscActive),
    .flagClr(flagClr), .sysResetReq(sysResetReq), .failFlag(failFlag)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One clock; sample after the edge and count requests.
  task automatic step(inout int got);
    @(negedge clk);
    if (sysResetReq) begin
      got++;
      if (prevHigh) dbl++;
    end
    prevHigh = sysResetReq;
  endtask

  task automatic idle(int n, inout int got);
    for (int i = 0; i < n; i++) step(got);
  endtask

  // Produce a crystal rising edge, then hold the crystal low.
  task automatic openEdge();
    int junk = 0;
    xtalLevel = 1'b1;
    step(junk);
    xtalLevel = 1'b0;
  endtask

  task automatic clearFlag();
    int junk = 0;
    flagClr = 1'b1;
    step(junk);
    flagClr = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int got;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 req", int'(sysResetReq), 0);
    check("R1 flag", int'(failFlag), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 / R3 sweep over the gap between crystal edges
    for (int n = 1; n <= 3 * PER + 2; n++) begin
      int junk = 0;
      xtalLevel = 1'b1;
      step(junk);
      xtalLevel = 1'b0;
      got = 0;
      idle(n, got);
      xtalLevel = 1'b1;
      step(got);
      xtalLevel = 1'b0;
      step(junk);
      check($sformatf("R2 R3 gap %0d", n), got, (n + 1) / PER);
    end
    check("R3 single cycle", dbl, 0);

    // R2 cycles without refTick do not count
    openEdge();
    refTick = 1'b0;
    got = 0;
    idle(3 * PER, got);
    check("R2 no ticks", got, 0);
    refTick = 1'b1;
    idle(PER, got);
    check("R2 ticks resume", got, 1);

    // R7 / R8 flag behaviour
    clearFlag();
    check("R8 clear", int'(failFlag), 0);
    openEdge();
    got = 0;
    idle(PER, got);
    check("R7 pulse", got, 1);
    check("R7 flag set", int'(failFlag), 1);
    openEdge();
    idle(3, got);
    check("R7 flag holds", int'(failFlag), 1);
    clearFlag();
    check("R8 cleared", int'(failFlag), 0);

    // R8 set wins over simultaneous clear
    openEdge();
    got = 0;
    idle(PER - 1, got);
    flagClr = 1'b1;
    step(got);
    flagClr = 1'b0;
    check("R8 set wins pulse", got, 1);
    check("R8 set wins flag", int'(failFlag), 1);

    // R4 disabled keeps flag at 1
    detectEn = 1'b0;
    openEdge();
    got = 0;
    idle(3 * PER, got);
    check("R4 no pulse flag1", got, 0);
    check("R4 flag kept 1", int'(failFlag), 1);
    detectEn = 1'b1;
    openEdge();
    clearFlag();
    // R4 disabled keeps flag at 0, then R9 late enable
    detectEn = 1'b0;
    openEdge();
    got = 0;
    idle(3 * PER, got);
    check("R4 no pulse flag0", got, 0);
    check("R4 flag kept 0", int'(failFlag), 0);
    detectEn = 1'b1;
    step(got);
    check("R9 late enable", got, 1);
    openEdge();
    clearFlag();

    // R5 stop mode suppresses and restarts the count
    openEdge();
    stopMode = 1'b1;
    got = 0;
    idle(3 * PER, got);
    check("R5 no pulse", got, 0);
    check("R5 no flag", int'(failFlag), 0);
    stopMode = 1'b0;
    idle(PER - 1, got);
    check("R5 restart early", got, 0);
    step(got);
    check("R5 restart pulse", got, 1);
    openEdge();
    clearFlag();

    // R6 ring oscillator suppresses and restarts the count
    openEdge();
    ringOscActive = 1'b1;
    got = 0;
    idle(3 * PER, got);
    check("R6 no pulse", got, 0);
    check("R6 no flag", int'(failFlag), 0);
    ringOscActive = 1'b0;
    idle(PER - 1, got);
    check("R6 restart early", got, 0);
    step(got);
    check("R6 restart pulse", got, 1);
    check("R3 single cycle end", dbl, 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule